// File: doc/BRIEF.md
# Condition Code Flag Generator

This combinational unit produces the negative, zero, overflow and carry flags for a small accumulator CPU that works on 8-bit and 16-bit data. The ALU computes its result somewhere else. This unit receives that result together with the two operands, an operation class and a width select. It returns the condition code byte with only the arithmetic flags rewritten.

Carry and overflow are not taken from an extra adder bit. They come from the sign bits of the two operands and the result. The sign bit is bit 7 in narrow mode and bit 15 in wide mode. For shifts, the shifter supplies the bit it shifted out. That bit becomes the carry, and overflow is set to the new negative flag XOR that carry. The test class clears overflow and keeps the carry that was there before. The upper four flag bits are never touched.

Condition byte layout, bit 7 down to bit 0: S, X, H, I, N, Z, V, C. Operation codes: 0 = add, 1 = subtract, 2 = shift, 3 = test. Width select: 0 = 8-bit, 1 = 16-bit.

Top module: `ccgen_flag_unit`

## Requirements
- R1: For add (op 0), C (bit 0) is set exactly when the unsigned sum of the operands at the selected width carries out of the sign bit.
- R2: For add, V (bit 1) is set exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R3: For subtract (op 1), C is set exactly when operand a is less than operand b as unsigned numbers at the selected width, which is the borrow case.
- R4: For subtract, V is set exactly when the operand sign bits differ and the result's sign bit differs from that of operand a.
- R5: For every class, N (bit 3) is the result's sign bit (bit 7 narrow, bit 15 wide), and Z (bit 2) is set exactly when all result bits of the selected width are zero.
- R6: For test (op 3), V is cleared and C keeps its incoming value.
- R7: For shift (op 2), C takes the value of the shift-carry input, and V equals the new N XOR that C.
- R8: In 8-bit mode, bits 15:8 of both operands and of the result have no effect on the output.
- R9: Bits 7:4 of the output (S, X, H, I) equal bits 7:4 of the incoming condition byte for every class.
- R10: Outside the shift class, the shift-carry input has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation class: 0 add, 1 subtract, 2 shift, 3 test |
| wide_i | input | 1 | 0 selects 8-bit width, 1 selects 16-bit width |
| opa_i | input | 16 | First ALU operand |
| opb_i | input | 16 | Second ALU operand |
| res_i | input | 16 | ALU result for this operation |
| shc_i | input | 1 | Bit shifted out by the shifter (used only by the shift class) |
| ccr_i | input | 8 | Incoming condition code byte |
| ccr_o | output | 8 | Updated condition code byte |

## Verification
The embedded checks assume that the result input is the true sum or difference of the operands for add and subtract. They also assume the operation class, width and operand inputs settle together. Under those assumptions, overflow can only appear when the operand signs relate as the requirements describe. The bench respects this: it builds every add and subtract result from the operands, masked to the selected width. Junk upper bits appear only in narrow mode, and there they are added on top of a correct low byte.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;

  typedef enum logic [1:0] {
    CC_ADD   = 2'd0,
    CC_SUB   = 2'd1,
    CC_SHIFT = 2'd2,
    CC_TEST  = 2'd3
  } cc_op_e;

  localparam int CCR_W    = 8;
  localparam int BIT_C    = 0;
  localparam int BIT_V    = 1;
  localparam int BIT_Z    = 2;
  localparam int BIT_N    = 3;
  localparam int KEEP_LO  = 4;

endpackage

// File: rtl/ccgen_msb_pick.sv
module ccgen_msb_pick #(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] opa_i,
  input  logic [WIDE_W-1:0] opb_i,
  input  logic [WIDE_W-1:0] res_i,
  output logic              a_msb_o,
  output logic              b_msb_o,
  output logic              r_msb_o,
  output logic              r_zero_o
);

  localparam int NMSB = NARROW_W - 1;
  localparam int WMSB = WIDE_W - 1;

  logic low_zero;
  logic high_zero;

  assign low_zero = ~|res_i[NMSB:0];

  generate
    if (WIDE_W > NARROW_W) begin : g_split
      assign high_zero = ~|res_i[WMSB:NARROW_W];
    end else begin : g_flat
      assign high_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    if (wide_i) begin
      a_msb_o  = opa_i[WMSB];
      b_msb_o  = opb_i[WMSB];
      r_msb_o  = res_i[WMSB];
      r_zero_o = low_zero & high_zero;
    end else begin
      a_msb_o  = opa_i[NMSB];
      b_msb_o  = opb_i[NMSB];
      r_msb_o  = res_i[NMSB];
      r_zero_o = low_zero;
    end
  end

endmodule

// File: rtl/ccgen_arith_flags.sv
module ccgen_arith_flags
  import ccgen_pkg::*;
(
  input  cc_op_e op_i,
  input  logic   a_msb_i,
  input  logic   b_msb_i,
  input  logic   r_msb_i,
  output logic   carry_o,
  output logic   ovf_o
);

  logic add_c, add_v, sub_c, sub_v;

  always_comb begin
    add_c = (a_msb_i & b_msb_i) | (b_msb_i & ~r_msb_i) | (a_msb_i & ~r_msb_i);
    add_v = (a_msb_i & b_msb_i & ~r_msb_i) | (~a_msb_i & ~b_msb_i & r_msb_i);
    sub_c = (~a_msb_i & b_msb_i) | (b_msb_i & r_msb_i) | (~a_msb_i & r_msb_i);
    sub_v = (a_msb_i & ~b_msb_i & ~r_msb_i) | (~a_msb_i & b_msb_i & r_msb_i);
  end

  always_comb begin
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    case (op_i)
      CC_ADD: begin
        carry_o = add_c;
        ovf_o   = add_v;
      end
      CC_SUB: begin
        carry_o = sub_c;
        ovf_o   = sub_v;
      end
      default: begin
        carry_o = 1'b0;
        ovf_o   = 1'b0;
      end
    endcase
  end

  // R2: add overflow only with like-signed operands
  always_comb begin
    if (op_i == CC_ADD && ovf_o)
      p_add_like_signs_r2 : assert (a_msb_i == b_msb_i);
  end

  // R4: subtract overflow only with unlike-signed operands
  always_comb begin
    if (op_i == CC_SUB && ovf_o)
      p_sub_unlike_signs_r4 : assert (a_msb_i != b_msb_i);
  end

endmodule

// File: rtl/ccgen_ccr_merge.sv
module ccgen_ccr_merge
  import ccgen_pkg::*;
(
  input  cc_op_e            op_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic              neg_i,
  input  logic              zero_i,
  input  logic              arith_c_i,
  input  logic              arith_v_i,
  input  logic              shc_i,
  output logic [CCR_W-1:0]  ccr_o
);

  logic next_c;
  logic next_v;

  always_comb begin
    next_c = ccr_i[BIT_C];
    next_v = 1'b0;
    case (op_i)
      CC_ADD, CC_SUB: begin
        next_c = arith_c_i;
        next_v = arith_v_i;
      end
      CC_SHIFT: begin
        next_c = shc_i;
        next_v = neg_i ^ shc_i;
      end
      default: begin
        next_c = ccr_i[BIT_C];
        next_v = 1'b0;
      end
    endcase
  end

  always_comb begin
    ccr_o                 = ccr_i;
    ccr_o[BIT_N]          = neg_i;
    ccr_o[BIT_Z]          = zero_i;
    ccr_o[BIT_V]          = next_v;
    ccr_o[BIT_C]          = next_c;
  end

endmodule

// File: rtl/ccgen_flag_unit.sv
module ccgen_flag_unit
  import ccgen_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] opa_i,
  input  logic [WIDE_W-1:0] opb_i,
  input  logic [WIDE_W-1:0] res_i,
  input  logic              shc_i,
  input  logic [CCR_W-1:0]  ccr_i,
  output logic [CCR_W-1:0]  ccr_o
);

  cc_op_e op;
  logic   a_msb, b_msb, r_msb, r_zero;
  logic   arith_c, arith_v;

  assign op = cc_op_e'(op_i);

  ccgen_msb_pick #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) u_pick (
    .wide_i   (wide_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .res_i    (res_i),
    .a_msb_o  (a_msb),
    .b_msb_o  (b_msb),
    .r_msb_o  (r_msb),
    .r_zero_o (r_zero)
  );

  ccgen_arith_flags u_arith (
    .op_i    (op),
    .a_msb_i (a_msb),
    .b_msb_i (b_msb),
    .r_msb_i (r_msb),
    .carry_o (arith_c),
    .ovf_o   (arith_v)
  );

  ccgen_ccr_merge u_merge (
    .op_i      (op),
    .ccr_i     (ccr_i),
    .neg_i     (r_msb),
    .zero_i    (r_zero),
    .arith_c_i (arith_c),
    .arith_v_i (arith_v),
    .shc_i     (shc_i),
    .ccr_o     (ccr_o)
  );

  // R9: upper flag nibble always passes through
  always_comb begin
    p_keep_upper_r9 : assert (ccr_o[CCR_W-1:KEEP_LO] == ccr_i[CCR_W-1:KEEP_LO]);
  end

  // R5: zero result can never look negative
  always_comb begin
    if (ccr_o[BIT_Z])
      p_zero_not_neg_r5 : assert (!ccr_o[BIT_N]);
  end

  // R6: test clears V and holds C
  always_comb begin
    if (op == CC_TEST)
      p_test_flags_r6 : assert (!ccr_o[BIT_V] && ccr_o[BIT_C] == ccr_i[BIT_C]);
  end

  // R7: shift overflow follows N xor C, carry from shifter
  always_comb begin
    if (op == CC_SHIFT)
      p_shift_ovf_r7 : assert (ccr_o[BIT_C] == shc_i &&
                               ccr_o[BIT_V] == (ccr_o[BIT_N] ^ ccr_o[BIT_C]));
  end

endmodule

// File: tb/ccgen_flag_unit_test.sv
module ccgen_flag_unit_test;

  logic        clk;
  logic        rst_n;
  logic [1:0]  op_i;
  logic        wide_i;
  logic [15:0] opa_i, opb_i, res_i;
  logic        shc_i;
  logic [7:0]  ccr_i;
  logic [7:0]  ccr_o;

  int total;
  int bad;
  bit done;

  ccgen_flag_unit uut (
    .op_i   (op_i),
    .wide_i (wide_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .res_i  (res_i),
    .shc_i  (shc_i),
    .ccr_i  (ccr_i),
    .ccr_o  (ccr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] model(input logic [1:0] op, input logic wide,
                                       input logic [15:0] a, input logic [15:0] b,
                                       input logic [15:0] r, input logic shc,
                                       input logic [7:0] ccr);
    logic [16:0] aa, bb, rr, full;
    int msb;
    logic n, z, v, c;
    msb = wide ? 15 : 7;
    aa = wide ? {1'b0, a} : {9'h0, a[7:0]};
    bb = wide ? {1'b0, b} : {9'h0, b[7:0]};
    rr = wide ? {1'b0, r} : {9'h0, r[7:0]};
    n = rr[msb];
    z = (rr == 17'h0);
    c = ccr[0];
    v = 1'b0;
    case (op)
      2'd0: begin
        full = aa + bb;
        c = full[msb+1];
        v = (aa[msb] == bb[msb]) && (rr[msb] != aa[msb]);
      end
      2'd1: begin
        c = (aa < bb);
        v = (aa[msb] != bb[msb]) && (rr[msb] != aa[msb]);
      end
      2'd2: begin
        c = shc;
        v = n ^ shc;
      end
      default: begin
        c = ccr[0];
        v = 1'b0;
      end
    endcase
    return {ccr[7:4], n, z, v, c};
  endfunction

  task automatic apply(input logic [1:0] op, input logic wide, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] r, input logic shc,
                       input logic [7:0] ccr);
    @(posedge clk);
    op_i = op; wide_i = wide; opa_i = a; opb_i = b; res_i = r; shc_i = shc; ccr_i = ccr;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    total++;
    if (ccr_o !== exp) begin
      bad++;
      $display("FAIL %s: ccr_o=%02h expected=%02h", tag, ccr_o, exp);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] op, input logic wide,
                     input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
                     input logic shc, input logic [7:0] ccr);
    apply(op, wide, a, b, r, shc, ccr);
    check(tag, model(op, wide, a, b, r, shc, ccr));
  endtask

  task automatic t_reset_state();
    apply(2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 8'h00);
    check("R5 idle zero", 8'h04);
  endtask

  task automatic t_add();
    run("R1 add8 carry",       2'd0, 1'b0, 16'h00F0, 16'h0020, 16'h0010, 1'b0, 8'h00);
    run("R2 add8 overflow",    2'd0, 1'b0, 16'h0070, 16'h0010, 16'h0080, 1'b0, 8'h00);
    run("R1 add8 zero carry",  2'd0, 1'b0, 16'h0080, 16'h0080, 16'h0000, 1'b0, 8'h00);
    run("R2 add16 overflow",   2'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 8'h00);
    run("R1 add16 carry",      2'd0, 1'b1, 16'hFFFF, 16'h0002, 16'h0001, 1'b0, 8'h00);
    check("R1 add16 carry exact", 8'h01);
  endtask

  task automatic t_sub();
    run("R3 sub8 borrow",      2'd1, 1'b0, 16'h0010, 16'h0020, 16'h00F0, 1'b0, 8'h00);
    check("R3 sub8 borrow exact", 8'h09);
    run("R4 sub8 overflow",    2'd1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 8'h00);
    run("R4 sub16 overflow",   2'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 8'h00);
    run("R3 sub16 equal",      2'd1, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b0, 8'h01);
    check("R5 sub16 zero exact", 8'h04);
  endtask

  task automatic t_shift();
    run("R7 shift c=1 n=1",    2'd2, 1'b0, 16'h00C0, 16'h0000, 16'h0080, 1'b1, 8'h00);
    run("R7 shift c=0 n=1",    2'd2, 1'b0, 16'h0040, 16'h0000, 16'h0080, 1'b0, 8'h00);
    check("R7 shift v exact", 8'h0A);
    run("R7 shift16 c=1 zero", 2'd2, 1'b1, 16'h8000, 16'h0000, 16'h0000, 1'b1, 8'h00);
    check("R7 shift16 exact", 8'h07);
  endtask

  task automatic t_test();
    run("R6 test16 neg",       2'd3, 1'b1, 16'h8001, 16'h0000, 16'h8001, 1'b0, 8'h03);
    check("R6 test16 exact", 8'h09);
    run("R6 test8 zero",       2'd3, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'h02);
    check("R6 test8 exact", 8'h04);
  endtask

  task automatic t_upper_ignored();
    run("R8 add8 junk upper",  2'd0, 1'b0, 16'hA570, 16'h5A10, 16'hFF80, 1'b0, 8'h00);
    check("R8 add8 junk exact", 8'h0A);
    run("R8 test8 junk upper", 2'd3, 1'b0, 16'h0000, 16'h0000, 16'hFF00, 1'b0, 8'h00);
    check("R8 test8 junk exact", 8'h04);
  endtask

  task automatic t_passthrough();
    run("R9 upper nibble add", 2'd0, 1'b0, 16'h0001, 16'h0001, 16'h0002, 1'b0, 8'hA0);
    check("R9 nibble A exact", 8'hA0);
    run("R9 upper nibble shf", 2'd2, 1'b1, 16'h0001, 16'h0000, 16'h0002, 1'b0, 8'h5F);
    check("R9 nibble 5 exact", 8'h50);
  endtask

  task automatic t_shc_ignored();
    run("R10 shc add",  2'd0, 1'b0, 16'h0001, 16'h0001, 16'h0002, 1'b1, 8'h00);
    check("R10 shc add exact", 8'h00);
    run("R10 shc sub",  2'd1, 1'b0, 16'h0005, 16'h0003, 16'h0002, 1'b1, 8'h00);
    run("R10 shc test", 2'd3, 1'b1, 16'h0001, 16'h0000, 16'h0001, 1'b1, 8'h00);
    check("R10 shc test exact", 8'h00);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0;
    op_i = 2'd0; wide_i = 1'b0; opa_i = '0; opb_i = '0; res_i = '0; shc_i = 1'b0; ccr_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_shift();
    t_test();
    t_upper_ignored();
    t_passthrough();
    t_shc_ignored();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule